// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page table entries so that a virtual page number can be turned into a physical page number without a memory access. The buffer holds 16 entries, organised as 4 sets of 4 ways. The low two bits of the virtual page number select a set. The remaining six bits form the tag, which is compared against all four ways of that set in the same cycle. On a hit, the block returns the physical address and the three stored permission bits. It does not judge the permission bits; the requester checks them.

On a miss, the block raises a walk request that carries the missing virtual page number. It then waits until an external page table walker supplies the entry on the fill port. Fills may also arrive at any other time. A fill overwrites a way that already holds the same tag. Otherwise it takes the lowest-numbered invalid way, and if the set is full it takes the way named by that set's rotating victim pointer. A single flush input empties the whole buffer in one cycle.

A three-state controller sequences requests. ST_IDLE accepts a request and moves to ST_LOOKUP. ST_LOOKUP presents the result. On a hit it either stays in ST_LOOKUP for a back-to-back request or returns to ST_IDLE. On a miss it moves to ST_WALK_WAIT. ST_WALK_WAIT returns to ST_IDLE when a fill arrives. A flush moves any state to ST_IDLE.

Top module: `tlb_top`

## Requirements
- R1: After reset, no entry is valid, the controller is in ST_IDLE, req_ready is 1, and resp_valid and walk_req are 0.
- R2: A virtual address selects set vaddr[7:6] and compares tag vaddr[13:8]. Pages that share a set but have different tags are held side by side, up to four per set.
- R3: A request accepted at a clock edge gives resp_valid=1 in the following cycle. On a hit, resp_paddr equals {stored page number, vaddr[5:0]} and resp_perm equals the stored permission bits (bit 2 supervisor, bit 1 read, bit 0 write).
- R4: On a miss, resp_hit is 0. From the next cycle until a fill arrives, walk_req is 1, walk_vpn holds vaddr[13:6] and req_ready is 0.
- R5: A fill that arrives while in ST_WALK_WAIT writes the entry and returns the controller to ST_IDLE for the next cycle.
- R6: A fill whose set and tag match a valid entry replaces that entry's page number and permissions. No other way changes.
- R7: A fill with no matching entry goes to the lowest-numbered invalid way of its set.
- R8: When all four ways are valid, the fill replaces the way named by that set's victim pointer. The pointer starts at 0 after reset, advances by one (modulo 4) only on such a replacement, and keeps its value through a flush.
- R9: flush_all clears every valid bit within one cycle, wins over a fill in the same cycle, and returns the controller to ST_IDLE.
- R10: No more than one way of a set ever matches a lookup, so a hit returns exactly one entry's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | 14 | Virtual address to translate |
| resp_valid | output | 1 | Lookup result present this cycle |
| resp_hit | output | 1 | Lookup found a valid matching entry |
| resp_paddr | output | 12 | Physical address on a hit, zero otherwise |
| resp_perm | output | 3 | Stored permission bits on a hit (supervisor, read, write) |
| walk_req | output | 1 | Entry needed from the page table walker |
| walk_vpn | output | 8 | Virtual page number being walked |
| fill_valid | input | 1 | Fill entry strobe |
| fill_vpn | input | 8 | Virtual page number of the fill |
| fill_ppn | input | 6 | Physical page number of the fill |
| fill_perm | input | 3 | Permission bits of the fill |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its default parameters: 14-bit virtual and 12-bit physical addresses, 64-byte pages, 4 sets and 4 ways. This makes the whole 256-page virtual space small enough to sweep upward and then downward. Each of those sweeps forces long runs of evictions through every set's victim pointer. A reference model in the bench, written from the fill rules, predicts every hit, miss, page number and permission value. Flushes that interrupt a pointer's rotation, overwrites of resident tags and a pseudo-random sequence confined to a few tags then drive the pointer and lowest-invalid choices through many different states.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PERM_W   = 3;
    localparam int PERM_SUP = 2;
    localparam int PERM_RD  = 1;
    localparam int PERM_WR  = 0;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOOKUP    = 2'd1,
        ST_WALK_WAIT = 2'd2
    } tlb_state_e;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      flush,
    input  logic                                      wr_en,
    input  logic [SET_W-1:0]                          wr_set,
    input  logic [WAY_W-1:0]                          wr_way,
    input  logic [TAG_W-1:0]                          wr_tag,
    input  logic [PPN_W-1:0]                          wr_ppn,
    input  logic [PERM_W-1:0]                         wr_perm,
    output logic [SETS-1:0][WAYS-1:0]                 valid_o,
    output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]      tag_o,
    output logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]      ppn_o,
    output logic [SETS-1:0][WAYS-1:0][PERM_W-1:0]     perm_o
);

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic sel;
            assign sel = wr_en && !flush &&
                         (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_o[s][w] <= 1'b0;
                end else if (flush) begin
                    valid_o[s][w] <= 1'b0;
                end else if (sel) begin
                    valid_o[s][w] <= 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_o[s][w]  <= '0;
                    ppn_o[s][w]  <= '0;
                    perm_o[s][w] <= '0;
                end else if (sel) begin
                    tag_o[s][w]  <= wr_tag;
                    ppn_o[s][w]  <= wr_ppn;
                    perm_o[s][w] <= wr_perm;
                end
            end
        end
    end

    p_flush_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_o == '0));

    p_write_sets_valid_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_o[$past(wr_set)][$past(wr_way)]);

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WAYS-1:0]                   valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]        tag_i,
    input  logic [WAYS-1:0][PPN_W-1:0]        ppn_i,
    input  logic [WAYS-1:0][PERM_W-1:0]       perm_i,
    input  logic [TAG_W-1:0]                  key,
    output logic                              hit,
    output logic [WAY_W-1:0]                  hit_way,
    output logic [PPN_W-1:0]                  hit_ppn,
    output logic [PERM_W-1:0]                 hit_perm
);

    logic [WAYS-1:0] way_oh;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_oh[w] = valid_i[w] && (tag_i[w] == key);
    end

    assign hit = |way_oh;

    always_comb begin
        hit_way  = '0;
        hit_ppn  = '0;
        hit_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_oh[w]) begin
                hit_way  = hit_way | WAY_W'(w);
                hit_ppn  = hit_ppn | ppn_i[w];
                hit_perm = hit_perm | perm_i[w];
            end
        end
    end

    p_single_match_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_oh));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic [SET_W-1:0]      alloc_set,
    input  logic [WAYS-1:0]       set_valid,
    output logic [WAY_W-1:0]      victim_way
);

    logic [SETS-1:0][WAY_W-1:0] ptr_q;
    logic                       set_full;
    logic [WAY_W-1:0]           free_way;

    assign set_full = &set_valid;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                free_way = WAY_W'(w);
            end
        end
    end

    assign victim_way = set_full ? ptr_q[alloc_set] : free_way;

    for (genvar s = 0; s < SETS; s++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[s] <= '0;
            end else if (alloc && set_full && (alloc_set == SET_W'(s))) begin
                ptr_q[s] <= (ptr_q[s] == WAY_W'(WAYS - 1)) ? '0 : ptr_q[s] + 1'b1;
            end
        end
    end

    p_ptr_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc && set_full) |=> $stable(ptr_q));

    p_free_first_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !set_full) |-> !set_valid[victim_way]);

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - SET_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  resp_valid,
    output logic                  resp_hit,
    output logic [PA_W-1:0]       resp_paddr,
    output logic [PERM_W-1:0]     resp_perm,
    output logic                  walk_req,
    output logic [VPN_W-1:0]      walk_vpn,
    input  logic                  fill_valid,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic [PERM_W-1:0]     fill_perm,
    input  logic                  flush_all
);

    tlb_state_e state_q, state_d;
    logic [VA_W-1:0] vaddr_q;
    logic            req_fire;

    logic [SETS-1:0][WAYS-1:0]             st_valid;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  st_tag;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  st_ppn;
    logic [SETS-1:0][WAYS-1:0][PERM_W-1:0] st_perm;

    logic [VPN_W-1:0]  lk_vpn;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [PPN_W-1:0]  lk_ppn;
    logic [PERM_W-1:0] lk_perm;

    logic [SET_W-1:0]  fl_set;
    logic [TAG_W-1:0]  fl_tag;
    logic              fl_hit;
    logic [WAY_W-1:0]  fl_match_way;
    logic [PPN_W-1:0]  fl_unused_ppn;
    logic [PERM_W-1:0] fl_unused_perm;
    logic [WAY_W-1:0]  fl_victim;
    logic [WAY_W-1:0]  fl_way;
    logic              fl_go;

    assign lk_vpn = vaddr_q[VA_W-1:OFF_W];
    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];

    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:SET_W];
    assign fl_go  = fill_valid && !flush_all;
    assign fl_way = fl_hit ? fl_match_way : fl_victim;

    tlb_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_all),
        .wr_en   (fill_valid),
        .wr_set  (fl_set),
        .wr_way  (fl_way),
        .wr_tag  (fl_tag),
        .wr_ppn  (fill_ppn),
        .wr_perm (fill_perm),
        .valid_o (st_valid),
        .tag_o   (st_tag),
        .ppn_o   (st_ppn),
        .perm_o  (st_perm)
    );

    tlb_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (st_valid[lk_set]),
        .tag_i    (st_tag[lk_set]),
        .ppn_i    (st_ppn[lk_set]),
        .perm_i   (st_perm[lk_set]),
        .key      (lk_tag),
        .hit      (lk_hit),
        .hit_way  (lk_way),
        .hit_ppn  (lk_ppn),
        .hit_perm (lk_perm)
    );

    tlb_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .PPN_W (PPN_W)
    ) u_fill_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (st_valid[fl_set]),
        .tag_i    (st_tag[fl_set]),
        .ppn_i    (st_ppn[fl_set]),
        .perm_i   (st_perm[fl_set]),
        .key      (fl_tag),
        .hit      (fl_hit),
        .hit_way  (fl_match_way),
        .hit_ppn  (fl_unused_ppn),
        .hit_perm (fl_unused_perm)
    );

    tlb_victim #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (fl_go && !fl_hit),
        .alloc_set  (fl_set),
        .set_valid  (st_valid[fl_set]),
        .victim_way (fl_victim)
    );

    always_comb begin
        req_ready = 1'b0;
        if (!flush_all) begin
            unique case (state_q)
                ST_IDLE:      req_ready = 1'b1;
                ST_LOOKUP:    req_ready = lk_hit;
                ST_WALK_WAIT: req_ready = 1'b0;
                default:      req_ready = 1'b0;
            endcase
        end
    end

    assign req_fire = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (!lk_hit)       state_d = ST_WALK_WAIT;
                else if (req_fire) state_d = ST_LOOKUP;
                else               state_d = ST_IDLE;
            end
            ST_WALK_WAIT: begin
                if (fill_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (flush_all) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_fire) vaddr_q <= req_vaddr;
        end
    end

    always_comb begin
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_paddr = '0;
        resp_perm  = '0;
        walk_req   = 1'b0;
        walk_vpn   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOKUP: begin
                resp_valid = 1'b1;
                resp_hit   = lk_hit;
                if (lk_hit) begin
                    resp_paddr = {lk_ppn, vaddr_q[OFF_W-1:0]};
                    resp_perm  = lk_perm;
                end
            end
            ST_WALK_WAIT: begin
                walk_req = 1'b1;
                walk_vpn = lk_vpn;
            end
            default: ;
        endcase
    end

    p_resp_follows_req_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !flush_all) |=> resp_valid);

    p_walk_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid && !flush_all) |=> (walk_req && $stable(walk_vpn)));

    p_miss_to_walk_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit && !flush_all) |=> walk_req);

    p_fill_done_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> (state_q == ST_IDLE));

    p_flush_idle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (!resp_valid && !walk_req));

    p_lookup_way_ok_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> st_valid[lk_set][lk_way]);

endmodule

// File: tb/tb_tlb_top.sv
module tb_tlb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [11:0] resp_paddr;
    logic [2:0]  resp_perm;
    logic        walk_req;
    logic [7:0]  walk_vpn;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_vpn = '0;
    logic [5:0]  fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_all = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tlb_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_paddr (resp_paddr),
        .resp_perm  (resp_perm),
        .walk_req   (walk_req),
        .walk_vpn   (walk_vpn),
        .fill_valid (fill_valid),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .fill_perm  (fill_perm),
        .flush_all  (flush_all)
    );

    // reference model built from the fill rules
    bit       mv   [4][4];
    int       mt   [4][4];
    int       mp   [4][4];
    int       mprm [4][4];
    int       mptr [4];

    function automatic int ppn_of(input int vpn);
        return (vpn * 5 + 1) % 64;
    endfunction

    function automatic int perm_of(input int vpn);
        return (vpn * 3) % 8;
    endfunction

    function automatic int m_find(input int vpn);
        int r = -1;
        for (int w = 0; w < 4; w++)
            if (mv[vpn % 4][w] && mt[vpn % 4][w] == vpn / 4) r = w;
        return r;
    endfunction

    function automatic void m_fill(input int vpn, input int ppn, input int perm);
        int s = vpn % 4;
        int way = m_find(vpn);
        if (way < 0)
            for (int w = 3; w >= 0; w--) if (!mv[s][w]) way = w;
        if (way < 0) begin
            way = mptr[s];
            mptr[s] = (mptr[s] + 1) % 4;
        end
        mv[s][way] = 1'b1;
        mt[s][way] = vpn / 4;
        mp[s][way] = ppn;
        mprm[s][way] = perm;
    endfunction

    function automatic void m_flush();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_lookup(input int vpn, input int off, input string hit_req);
        int w;
        int va = vpn * 64 + off;
        @(negedge clk);
        chk("R4 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = va[13:0];
        @(negedge clk);
        req_valid = 1'b0;
        w = m_find(vpn);
        chk("R3 resp_valid", int'(resp_valid), 1);
        chk(hit_req, int'(resp_hit), (w >= 0) ? 1 : 0);
        if (w >= 0) begin
            chk("R3 paddr", int'(resp_paddr), mp[vpn % 4][w] * 64 + off);
            chk("R3 perm", int'(resp_perm), mprm[vpn % 4][w]);
        end else begin
            @(negedge clk);
            chk("R4 walk_req", int'(walk_req), 1);
            chk("R4 walk_vpn", int'(walk_vpn), vpn);
            chk("R4 ready low", int'(req_ready), 0);
            fill_valid = 1'b1;
            fill_vpn = vpn[7:0];
            fill_ppn = 6'(ppn_of(vpn));
            fill_perm = 3'(perm_of(vpn));
            @(negedge clk);
            fill_valid = 1'b0;
            m_fill(vpn, ppn_of(vpn), perm_of(vpn));
            chk("R5 walk cleared", int'(walk_req), 0);
            chk("R5 back to idle", int'(req_ready), 1);
        end
    endtask

    task automatic do_fill(input int vpn, input int ppn, input int perm, input bit fl);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn = vpn[7:0];
        fill_ppn = ppn[5:0];
        fill_perm = perm[2:0];
        flush_all = fl;
        @(negedge clk);
        fill_valid = 1'b0;
        flush_all = 1'b0;
        if (fl) m_flush();
        else m_fill(vpn, ppn, perm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int s = 0; s < 4; s++) begin
            mptr[s] = 0;
            for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 resp_valid after reset", int'(resp_valid), 0);
        chk("R1 walk_req after reset", int'(walk_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'(req_ready), 1);
        do_lookup(8'h35, 6'h11, "R1 empty buffer misses");

        // R2: full sweeps over every page, up then down
        for (int v = 0; v < 256; v++) do_lookup(v, (v * 7) % 64, "R2 hit sweep up");
        for (int v = 255; v >= 0; v--) do_lookup(v, (v * 11) % 64, "R2 hit sweep down");

        // R6 / R10: overwrite a resident tag with new data
        do_lookup(8'h22, 6'h05, "R6 resident");
        do_fill(8'h22, 6'h3C, 5, 1'b0);
        do_lookup(8'h22, 6'h2A, "R6 overwrite hit");
        do_lookup(8'h22, 6'h00, "R10 single match");
        for (int t = 0; t < 8; t++) do_lookup(t * 4 + 2, t, "R6 neighbours kept");

        // R9: flush, then flush against a simultaneous fill
        do_fill(0, 0, 0, 1'b1);
        for (int v = 0; v < 8; v++) do_lookup(v * 9, 3, "R9 miss after flush");
        do_fill(8'h41, 6'h12, 3, 1'b1);
        do_lookup(8'h41, 6'h01, "R9 flush beats fill");

        // R7 / R8: fill one set from empty, then overflow it
        do_fill(0, 0, 0, 1'b1);
        for (int t = 0; t < 5; t++) do_fill(t * 4 + 1, t + 40, t, 1'b0);
        for (int t = 0; t < 5; t++) do_lookup(t * 4 + 1, t, "R7 lowest free way");
        for (int t = 5; t < 10; t++) do_fill(t * 4 + 1, t + 40, t, 1'b0);
        for (int t = 0; t < 10; t++) do_lookup(t * 4 + 1, t, "R8 victim rotation");

        // R8: pseudo-random traffic over few tags
        lfsr = 32'h1D;
        for (int i = 0; i < 400; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
            if (lfsr % 53 == 0) do_fill(0, 0, 0, 1'b1);
            do_lookup(lfsr % 24, lfsr % 64, "R8 random hit");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule